// File: doc/BRIEF.md
# Processor Bus Address Decoder

This block sits between a processor bus with a 16-bit address and 8-bit data and a set of eight byte-wide memory banks. It also serves one input port and one output latch. Each bus access carries an address, an address-valid strobe and a direction line (high for read, low for write). The block turns the top address bits and the strobe into active-low bank selects, and passes the low address bits on as the location inside the selected bank. It steers the right byte back onto the read-data path.

The input port and the output latch share one address, 0000 hex. A read there returns the live input port value. A write there loads the output latch. Writing a byte to that address and then reading it back therefore returns whatever the input port shows, not the byte written. The port decode wins over bank 0 at that address, so bank 0 is never selected there.

The interface is a plain bus and not a stream: there is no valid/ready pair and no back-pressure. Every access completes in the cycle it is presented. Read data and the flags follow the inputs combinationally. The output latch and the bank contents change on the rising clock edge.

Top module: `addr_dec_top`

## Requirements
- R1: While `addr_valid` is low, every bit of `bank_cs_n` is high.
- R2: While `addr_valid` is high and the address is not 0000, exactly one select is low: `bank_cs_n[i]` with i = `bus_addr[15:13]`. Bank 1 covers 2000–3FFF, bank 0 covers 0000–1FFF, and so on up to bank 7 at E000–FFFF.
- R3: `bank_loc` always equals `bus_addr[12:0]`, the location inside the selected bank.
- R4: At address 0000 with `addr_valid` high, the port decode takes priority: no bank select is low, bank 0 included.
- R5: `out_port` is 00 after reset. It loads `wdata` on the rising edge when `addr_valid` is high, `bus_read` is low and the address is 0000. At every other edge it holds its value.
- R6: A read at address 0000 with `addr_valid` high returns `in_port`, not the last byte written to that address.
- R7: A read with `addr_valid` high at any other address returns the data of the selected bank, taken from lane i of `bank_rdata` (bits 8i+7..8i).
- R8: A read (`bus_read` high) with no device selected, including while `addr_valid` is low, returns 00 on `rdata` and raises `no_dev`. Otherwise `no_dev` is low.
- R9: While `bus_read` is low (a write), `rdata` is 00 and `no_dev` is low.
- R10: A bank whose select is low during a write stores `wdata` at `bank_loc`, and a later read of the same address returns that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 16 | Processor address |
| addr_valid | input | 1 | Address-valid strobe; qualifies every select |
| bus_read | input | 1 | 1 = read, 0 = write |
| wdata | input | 8 | Processor write data |
| rdata | output | 8 | Read data steered back to the processor |
| no_dev | output | 1 | High during a read that selects no device |
| bank_cs_n | output | 8 | Active-low bank selects, bit i for bank i |
| bank_loc | output | 13 | Location inside the selected bank |
| bank_rdata | input | 64 | Read lanes from the banks, lane i at bits 8i+7..8i |
| in_port | input | 8 | Input port value |
| out_port | output | 8 | Output latch value |

## Verification
Port decoding and bank 0 decoding fall in the same cycle whenever the strobe is high at address 0000. A write there must load the output latch while `bank_cs_n[0]` stays high. A read there must return `in_port` and not bank 0's lane. The bench provokes this with directed writes and reads at 0000 between accesses to bank 0 locations 0001 and 1FFF. It sets the input port to a value that differs from the byte just written and fills bank 0 with data that would show if it were wrongly selected. A reference model that updates every clock judges the select vector, the read data and the latch. Random traffic biased towards address 0000 and the bank edges repeats the same collision many times.

// File: rtl/addr_dec_pkg.sv
package addr_dec_pkg;

  // Which source drives the read-data path in the current cycle.
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_PORT = 2'd1,
    SRC_BANK = 2'd2
  } rd_src_t;

  localparam int DEF_ADDR_W   = 16;
  localparam int DEF_DATA_W   = 8;
  localparam int DEF_SEL_BITS = 3;

endpackage

// File: rtl/ad_bank_select.sv
module ad_bank_select #(
  parameter int SEL_BITS = 3,
  localparam int NB = 1 << SEL_BITS
) (
  input  logic [SEL_BITS-1:0] sel,
  input  logic                strobe,
  input  logic                port_hit,
  output logic [NB-1:0]       cs_n,
  output logic                any_sel
);

  // A bank may be selected only while the strobe is high and the port decode
  // has not claimed the access.
  logic bank_ok;
  assign bank_ok = strobe && !port_hit;

  for (genvar g = 0; g < NB; g++) begin : g_bank
    assign cs_n[g] = !(bank_ok && (sel == SEL_BITS'(g)));
  end

  assign any_sel = !(&cs_n);

endmodule

// File: rtl/ad_port_unit.sv
module ad_port_unit #(
  parameter int              ADDR_W    = 16,
  parameter int              DATA_W    = 8,
  parameter logic [ADDR_W-1:0] PORT_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              strobe,
  input  logic              rd_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic              port_hit,
  output logic [DATA_W-1:0] out_latch
);

  logic load_en;

  assign port_hit = strobe && (addr == PORT_ADDR);
  assign load_en  = port_hit && !rd_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_latch <= '0;
    end else if (load_en) begin
      out_latch <= wdata;
    end
  end

endmodule

// File: rtl/ad_read_steer.sv
module ad_read_steer
  import addr_dec_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int SEL_BITS = 3,
  localparam int NB = 1 << SEL_BITS
) (
  input  rd_src_t              src,
  input  logic                 rd_wr,
  input  logic [SEL_BITS-1:0]  sel,
  input  logic [NB*DATA_W-1:0] bank_lanes,
  input  logic [DATA_W-1:0]    in_port,
  output logic [DATA_W-1:0]    rdata,
  output logic                 no_dev
);

  logic [DATA_W-1:0] lane [NB];

  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign lane[g] = bank_lanes[g*DATA_W +: DATA_W];
  end

  always_comb begin
    rdata  = '0;
    no_dev = 1'b0;
    if (rd_wr) begin
      unique case (src)
        SRC_PORT: rdata = in_port;
        SRC_BANK: rdata = lane[sel];
        default:  no_dev = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/addr_dec_top.sv
module addr_dec_top
  import addr_dec_pkg::*;
#(
  parameter int ADDR_W   = DEF_ADDR_W,
  parameter int DATA_W   = DEF_DATA_W,
  parameter int SEL_BITS = DEF_SEL_BITS,
  parameter logic [ADDR_W-1:0] PORT_ADDR = '0,
  localparam int NB    = 1 << SEL_BITS,
  localparam int LOC_W = ADDR_W - SEL_BITS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 addr_valid,
  input  logic                 bus_read,
  input  logic [DATA_W-1:0]    wdata,
  output logic [DATA_W-1:0]    rdata,
  output logic                 no_dev,
  output logic [NB-1:0]        bank_cs_n,
  output logic [LOC_W-1:0]     bank_loc,
  input  logic [NB*DATA_W-1:0] bank_rdata,
  input  logic [DATA_W-1:0]    in_port,
  output logic [DATA_W-1:0]    out_port
);

  logic [SEL_BITS-1:0] sel;
  logic                port_hit;
  logic                any_sel;
  rd_src_t             src;

  assign sel      = bus_addr[ADDR_W-1 -: SEL_BITS];
  assign bank_loc = bus_addr[LOC_W-1:0];

  ad_port_unit #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PORT_ADDR(PORT_ADDR)
  ) u_port (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .strobe(addr_valid),
    .rd_wr(bus_read), .wdata(wdata), .port_hit(port_hit), .out_latch(out_port)
  );

  ad_bank_select #(.SEL_BITS(SEL_BITS)) u_sel (
    .sel(sel), .strobe(addr_valid), .port_hit(port_hit),
    .cs_n(bank_cs_n), .any_sel(any_sel)
  );

  always_comb begin
    if (!addr_valid)   src = SRC_NONE;
    else if (port_hit) src = SRC_PORT;
    else if (any_sel)  src = SRC_BANK;
    else               src = SRC_NONE;
  end

  ad_read_steer #(.DATA_W(DATA_W), .SEL_BITS(SEL_BITS)) u_steer (
    .src(src), .rd_wr(bus_read), .sel(sel), .bank_lanes(bank_rdata),
    .in_port(in_port), .rdata(rdata), .no_dev(no_dev)
  );

endmodule

// File: rtl/addr_dec_check.sv
module addr_dec_check #(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int SEL_BITS = 3,
  parameter logic [ADDR_W-1:0] PORT_ADDR = '0,
  localparam int NB = 1 << SEL_BITS
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              addr_valid,
  input logic              bus_read,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic              no_dev,
  input logic [NB-1:0]     bank_cs_n,
  input logic [DATA_W-1:0] out_port
);

  logic port_wr;
  assign port_wr = addr_valid && !bus_read && (bus_addr == PORT_ADDR);

  assert_no_cs_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_valid |-> (&bank_cs_n));

  assert_single_cs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~bank_cs_n));

  assert_bank_pick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && bus_addr != PORT_ADDR) |->
      !bank_cs_n[bus_addr[ADDR_W-1 -: SEL_BITS]]);

  assert_port_priority_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && bus_addr == PORT_ADDR) |-> (&bank_cs_n));

  assert_latch_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    port_wr |=> (out_port == $past(wdata)));

  assert_latch_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !port_wr |=> $stable(out_port));

  assert_nodev_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    no_dev |-> (rdata == '0 && bus_read));

  assert_write_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_read |-> (rdata == '0 && !no_dev));

endmodule

bind addr_dec_top addr_dec_check #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_BITS(SEL_BITS), .PORT_ADDR(PORT_ADDR)
) u_check (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .addr_valid(addr_valid),
  .bus_read(bus_read), .wdata(wdata), .rdata(rdata), .no_dev(no_dev),
  .bank_cs_n(bank_cs_n), .out_port(out_port)
);

// File: tb/tb_addr_dec_top.sv
`timescale 1ns/1ps
module tb_addr_dec_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic        addr_valid = 1'b0;
  logic        bus_read = 1'b1;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        no_dev;
  logic [7:0]  bank_cs_n;
  logic [12:0] bank_loc;
  logic [63:0] bank_rdata = '0;
  logic [7:0]  in_port = '0;
  logic [7:0]  out_port;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Bank contents as the bench's memory devices (written by the DUT selects)
  logic [7:0] bank_mem [int];
  // Reference memory and latch (updated from the requirements only)
  logic [7:0] ref_mem [int];
  logic [7:0] ref_latch = '0;

  always #2.5 clk = ~clk;

  addr_dec_top dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .addr_valid(addr_valid),
    .bus_read(bus_read), .wdata(wdata), .rdata(rdata), .no_dev(no_dev),
    .bank_cs_n(bank_cs_n), .bank_loc(bank_loc), .bank_rdata(bank_rdata),
    .in_port(in_port), .out_port(out_port)
  );

  function automatic logic [7:0] bank_get(int key);
    if (bank_mem.exists(key)) return bank_mem[key];
    return 8'h00;
  endfunction

  function automatic logic [7:0] ref_get(int key);
    if (ref_mem.exists(key)) return ref_mem[key];
    return 8'h00;
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (addr %h valid %0b read %0b)",
               tag, act, exp, bus_addr, addr_valid, bus_read);
    end
  endtask

  // One bus cycle: drive at the falling edge, compare, then commit at the rising edge.
  task automatic access(logic [15:0] a, logic v, logic rd, logic [7:0] wd,
                        logic [7:0] inp);
    logic [7:0]  exp_cs;
    logic [7:0]  exp_rd;
    logic        exp_nd;
    string       cs_tag;
    string       rd_tag;
    @(negedge clk);
    bus_addr = a; addr_valid = v; bus_read = rd; wdata = wd; in_port = inp;
    for (int i = 0; i < 8; i++)
      bank_rdata[i*8 +: 8] = bank_get(int'({3'(i), a[12:0]}));
    #1;
    // expected selects
    exp_cs = 8'hFF;
    if (!v)            cs_tag = "R1";
    else if (a == 0)   cs_tag = "R4";
    else begin
      cs_tag = "R2";
      exp_cs[a[15:13]] = 1'b0;
    end
    // expected read path
    exp_nd = 1'b0;
    if (!rd)          begin exp_rd = 8'h00;       rd_tag = "R9"; end
    else if (!v)      begin exp_rd = 8'h00;       rd_tag = "R8"; exp_nd = 1'b1; end
    else if (a == 0)  begin exp_rd = inp;         rd_tag = "R6"; end
    else              begin exp_rd = ref_get(int'(a)); rd_tag = "R7 R10"; end
    check(cs_tag, 16'(bank_cs_n), 16'(exp_cs));
    check("R3", 16'(bank_loc), 16'(a[12:0]));
    check(rd_tag, 16'(rdata), 16'(exp_rd));
    check("R8 no_dev", 16'(no_dev), 16'(exp_nd));
    check("R5 latch", 16'(out_port), 16'(ref_latch));
    @(posedge clk);
    for (int i = 0; i < 8; i++)
      if (!bank_cs_n[i] && !bus_read)
        bank_mem[int'({3'(i), bank_loc})] = wdata;
    if (v && !rd && a == 0) ref_latch = wd;
    if (v && !rd && a != 0) ref_mem[int'(a)] = wd;
  endtask

  initial begin
    logic [15:0] ra;
    repeat (3) @(posedge clk);
    #1;
    check("R5 reset", 16'(out_port), 16'h0000);
    rst_n = 1'b1;

    // R1/R8: idle reads with the strobe low
    access(16'h2000, 1'b0, 1'b1, 8'h00, 8'h11);
    access(16'h0000, 1'b0, 1'b1, 8'h00, 8'h22);
    // R1: a write with the strobe low must select nothing and store nothing
    access(16'h4001, 1'b0, 1'b0, 8'hEE, 8'h00);
    access(16'h4001, 1'b1, 1'b1, 8'h00, 8'h00);

    // R2/R10: write one location in each bank, including the range edges
    for (int i = 0; i < 8; i++) begin
      access(16'(i * 16'h2000 + 16'h0123), 1'b1, 1'b0, 8'(8'h10 + i), 8'h00);
      access(16'(i * 16'h2000 + 16'h1FFF), 1'b1, 1'b0, 8'(8'h80 + i), 8'h00);
    end
    access(16'h0001, 1'b1, 1'b0, 8'h9C, 8'h00);
    // R7: read them back
    for (int i = 0; i < 8; i++) begin
      access(16'(i * 16'h2000 + 16'h0123), 1'b1, 1'b1, 8'h00, 8'h00);
      access(16'(i * 16'h2000 + 16'h1FFF), 1'b1, 1'b1, 8'h00, 8'h00);
    end
    // R2: bank 1 boundary at 2000
    access(16'h2000, 1'b1, 1'b0, 8'h5E, 8'h00);
    access(16'h2000, 1'b1, 1'b1, 8'h00, 8'h00);

    // R4/R5/R6: shared port address; write then read returns the input port
    access(16'h0000, 1'b1, 1'b0, 8'h5A, 8'hA5);
    access(16'h0000, 1'b1, 1'b1, 8'h00, 8'hA5);
    access(16'h0001, 1'b1, 1'b1, 8'h00, 8'h3C);
    // R5: latch holds across other writes and reads
    access(16'hE000, 1'b1, 1'b0, 8'h77, 8'h00);
    access(16'h0000, 1'b1, 1'b1, 8'h00, 8'h01);
    access(16'h0000, 1'b1, 1'b0, 8'h33, 8'hCC);
    access(16'h0000, 1'b0, 1'b0, 8'h44, 8'hCC);
    access(16'h0001, 1'b1, 1'b1, 8'h00, 8'h00);

    // Random traffic biased toward the port address and bank edges
    for (int n = 0; n < 2000; n++) begin
      case ($urandom_range(0, 5))
        0: ra = 16'h0000;
        1: ra = 16'($urandom_range(0, 7) * 16'h2000);
        2: ra = 16'($urandom_range(0, 7) * 16'h2000 + 16'h1FFF);
        3: ra = 16'($urandom_range(0, 7) * 16'h2000 + $urandom_range(0, 3));
        default: ra = 16'($urandom_range(0, 65535));
      endcase
      access(ra, 1'($urandom_range(0, 5) != 0), 1'($urandom_range(0, 1)),
             8'($urandom_range(0, 255)), 8'($urandom_range(0, 255)));
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    #(5 * 100000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

endmodule